// File: doc/BRIEF.md
# Cycle-Stealing Block Copy Engine

This block copies a run of words from one region of memory to another without further help from the processor once it has been started. The processor loads a source start address, a destination start address and a word count through a small register port, then writes the start bit. Each word moves as two accesses on the single shared memory port: a read of the source word, then a write of that word to the destination.

The engine never asks for the bus. The processor's memory request input tells the engine whether the port is taken. The engine issues an access only in a cycle where that input is low. If the processor takes the port between the read and the write of a word, the engine waits and keeps the word it has read. After the last word has been written, a done flag rises and stays high until the next start. A start with a count of zero raises the flag at once and makes no access.

Top module: `dma_steal`

## Requirements
- R1: The register port decodes `reg_addr_i` as follows: 0 loads the source start address, 1 loads the destination start address, 2 loads the word count, and 3 is control, where a write with `reg_wdata_i[0]`=1 starts a transfer.
- R2: A start with a nonzero count, written while idle, sets `busy_o` and clears `done_o` at the clock edge that takes the write.
- R3: `mem_req_o` is never high in a cycle where `cpu_req_i` is high.
- R4: Each word is moved by a read (`mem_we_o`=0) at its source address, followed by a write (`mem_we_o`=1) to its destination address that carries the `mem_rdata_i` value sampled in the read cycle.
- R5: Words move in ascending order. Both addresses advance by one per word, starting at the programmed values.
- R6: After exactly count words, `busy_o` falls and `done_o` rises at the edge of the last write. `done_o` then holds until the next accepted start.
- R7: A start with a count of zero sets `done_o` at the start edge, leaves `busy_o` low and makes no memory access.
- R8: While `busy_o` is high, register writes to any address, including a second start, have no effect on the running transfer.
- R9: After reset, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | AW | Register write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer finished |
| cpu_req_i | input | 1 | Processor is using the memory port this cycle |
| mem_req_o | output | 1 | Engine access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the same cycle as the read |

## Verification
The assertions assume that memory returns read data combinationally in the cycle of the read. They also assume that `cpu_req_i` changes only between clock edges. The bench models memory as a combinational array, and it drives the processor request just after each rising edge, as a steady low, as a random pattern or as a long high stretch. The source and destination regions are kept apart, so each expected read value is known when the transfer is queued. No start is issued while a transfer runs unless that start is meant to be ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dma_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_LEN  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o
);
  import dma_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_SRC: src_o <= wr_data_i;
        SEL_DST: dst_o <= wr_data_i;
        SEL_LEN: cnt_o <= CW'(wr_data_i);
        default: ;
      endcase
    end else if (step_i) begin
      src_o <= src_o + AW'(1);
      dst_o <= dst_o + AW'(1);
      cnt_o <= cnt_o - CW'(1);
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic len_zero_i,
  input  logic last_i,
  input  logic cpu_req_i,
  output logic busy_o,
  output logic done_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic rd_fire_o,
  output logic wr_fire_o
);
  import dma_pkg::*;

  dma_state_e state_q, state_d;
  logic       done_q;

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_fire_o = (state_q == ST_RD) && !cpu_req_i;
  assign wr_fire_o = (state_q == ST_WR) && !cpu_req_i;
  assign mem_req_o = rd_fire_o || wr_fire_o;
  assign mem_we_o  = wr_fire_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i && !len_zero_i) state_d = ST_RD;
      ST_RD:   if (rd_fire_o) state_d = ST_WR;
      ST_WR:   if (wr_fire_o) state_d = last_i ? ST_IDLE : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i && !busy_o) done_q <= len_zero_i;
      else if (wr_fire_o && last_i) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_steal.sv
module dma_steal #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic          cpu_req_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  import dma_pkg::*;

  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic          start, cfg_wr, rd_fire, wr_fire;
  logic [DW-1:0] word_q;

  // config and start accepted only while idle
  assign cfg_wr = reg_we_i && !busy_o && (reg_addr_i != SEL_CTRL);
  assign start  = reg_we_i && !busy_o && (reg_addr_i == SEL_CTRL) && reg_wdata_i[0];

  dma_regs #(.AW(AW), .CW(CW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_wr),
    .wr_sel_i  (reg_addr_i),
    .wr_data_i (reg_wdata_i),
    .step_i    (wr_fire),
    .src_o     (src),
    .dst_o     (dst),
    .cnt_o     (cnt)
  );

  dma_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .len_zero_i (cnt == '0),
    .last_i     (cnt == CW'(1)),
    .cpu_req_i  (cpu_req_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .rd_fire_o  (rd_fire),
    .wr_fire_o  (wr_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (rd_fire) word_q <= mem_rdata_i;
  end

  assign mem_addr_o  = mem_we_o ? dst : src;
  assign mem_wdata_o = word_q;
endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [AW-1:0] reg_wdata_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          cpu_req_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i
);
  logic          seen_rd;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] rd_addr;
  logic          acc_start;

  assign acc_start = reg_we_i && !busy_o && (reg_addr_i == 2'd3) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_rd <= 1'b0;
      rd_data <= '0;
      rd_addr <= '0;
    end else if (acc_start) begin
      seen_rd <= 1'b0;
    end else if (mem_req_o && !mem_we_o) begin
      seen_rd <= 1'b1;
      rd_data <= mem_rdata_i;
      rd_addr <= mem_addr_o;
    end
  end

  AST_NO_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |-> !mem_req_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R7
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_READ_STAYS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> busy_o); // R4
  AST_WDATA_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (seen_rd && mem_wdata_o == rd_data)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && seen_rd && !acc_start) |-> mem_addr_o == rd_addr + AW'(1)); // R5
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_start) |=> (busy_o || done_o)); // R2
endmodule

bind dma_steal dma_steal_chk #(.AW(AW), .DW(DW)) i_dma_steal_chk (.*);

// File: tb/test_dma_steal.sv
module test_dma_steal;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          busy, done, cpu_req, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [256];
  int total = 0, bad = 0;
  int cpu_mode = 0;     // 0 free, 1 random, 2 held
  int acc_cnt = 0;
  logic [AW+DW:0] exp_q [$];   // {we, addr, data}

  always #(CLK_P/2) clk = ~clk;

  dma_steal #(.AW(AW), .DW(DW), .CW(16)) i_dma_steal (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .busy_o(busy), .done_o(done), .cpu_req_i(cpu_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata));

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  initial cpu_req = 1'b0;
  always @(posedge clk) begin
    #1;
    case (cpu_mode)
      1: cpu_req <= ($urandom % 2) == 0;
      2: cpu_req <= 1'b1;
      default: cpu_req <= 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected accesses at the falling edge
  always @(negedge clk) if (rst_n && mem_req) begin
    logic [AW+DW:0] e;
    acc_cnt++;
    check(!cpu_req, "R3 clash", 1, 0);
    if (exp_q.size() == 0) check(1'b0, "R8 extra access", int'(mem_addr), -1);
    else begin
      e = exp_q.pop_front();
      check(mem_we == e[AW+DW], "R4 access kind", int'(mem_we), int'(e[AW+DW]));
      check(mem_addr == e[AW+DW-1:DW], "R5 address", int'(mem_addr), int'(e[AW+DW-1:DW]));
      if (e[AW+DW]) check(mem_wdata == e[DW-1:0], "R4 write data", int'(mem_wdata), int'(e[DW-1:0]));
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [AW-1:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  // driver: pushes the expected access sequence
  task automatic queue_copy(input int s, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b0, AW'(s + i), mem[(s + i) % 256]});
      exp_q.push_back({1'b1, AW'(d + i), mem[(s + i) % 256]});
    end
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 5000) begin @(posedge clk); #1; t++; end
    check(done == 1'b1, req, int'(done), 1);
  endtask

  task automatic run_copy(input int s, input int d, input int n, input int mode);
    cpu_mode = mode;
    wr_reg(2'd0, AW'(s)); wr_reg(2'd1, AW'(d)); wr_reg(2'd2, AW'(n));
    queue_copy(s, d, n);
    wr_reg(2'd3, 16'h1);
    check(busy == 1'b1 && done == 1'b0, "R2 start", int'({busy, done}), 2);
    wait_done("R6 done rises");
    check(busy == 1'b0, "R6 idle at done", int'(busy), 0);
    check(exp_q.size() == 0, "R6 word count", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0;
    for (int i = 0; i < 256; i++) mem[i] = DW'(16'hA500 ^ (i * 37));
    #(CLK_P * 2 + 3); rst_n = 1'b1;
    check(!busy && !done && !mem_req, "R9 reset", int'({busy, done, mem_req}), 0);

    run_copy(8, 128, 5, 0);      // R1 R4 R5 free bus
    for (int i = 0; i < 5; i++)
      check(mem[128 + i] == mem[8 + i], "R4 copied word", int'(mem[128 + i]), int'(mem[8 + i]));

    run_copy(20, 160, 9, 1);     // random stealing
    run_copy(40, 200, 1, 1);     // single word

    // R6: done holds while idle
    repeat (10) @(posedge clk); #1;
    check(done == 1'b1, "R6 done holds", int'(done), 1);

    // R7: zero length
    a0 = acc_cnt;
    wr_reg(2'd2, 16'd0); wr_reg(2'd3, 16'h1);
    check(done == 1'b1 && busy == 1'b0, "R7 zero length", int'({busy, done}), 1);
    repeat (5) @(posedge clk); #1;
    check(acc_cnt == a0, "R7 no access", acc_cnt, a0);

    // R3: bus held by cpu, then released; R8: writes during busy ignored
    cpu_mode = 2;
    wr_reg(2'd0, 16'd60); wr_reg(2'd1, 16'd100); wr_reg(2'd2, 16'd4);
    queue_copy(60, 100, 4);
    a0 = acc_cnt;
    wr_reg(2'd3, 16'h1);
    check(done == 1'b0 && busy == 1'b1, "R2 start clears done", int'({busy, done}), 2);
    wr_reg(2'd0, 16'd3); wr_reg(2'd1, 16'd7); wr_reg(2'd2, 16'd50); wr_reg(2'd3, 16'h1);
    repeat (20) @(posedge clk); #1;
    check(acc_cnt == a0, "R3 held bus", acc_cnt, a0);
    cpu_mode = 1;
    wait_done("R8 done after ignored writes");
    check(exp_q.size() == 0, "R8 length unchanged", exp_q.size(), 0);
    repeat (10) @(posedge clk); #1;
    check(busy == 1'b0 && exp_q.size() == 0, "R8 no restart", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule